// File: doc/BRIEF.md
# Memory-to-Memory Copy Channel

This block is a single copy engine that moves a run of 16-bit or 32-bit units from one memory range to another. Software loads a source pointer, a destination pointer and a 32-bit command word through a small write port. The copy is armed when the command's enable bit goes from 0 to 1. The copy then begins at once, or it waits for a pulse on the request line that matches its start mode. In the FIFO-fed start mode, each request moves a bounded burst, and the channel then waits for the next request. It keeps its place between bursts.

Each unit is one read followed by one write on a single-beat valid/ready master port. A request is presented with `mem_valid` and holds its address, direction, size and write data until the cycle in which `mem_ready` is high. The memory may hold `mem_ready` low for as long as it needs, and the channel then waits. After every write the channel stays idle for a number of cycles. That number is the sum of the wait-state costs of the source region and the destination region. A stall line tells the processor that the channel owns the memory. A one-cycle interrupt marks the end of the whole transfer.

Top module: `mdma_channel`

## Requirements
- R1: A control write (`reg_sel`=2) arms the channel only when its bit 31 is 1 and the stored bit 31 is 0. Arming copies the programmed pointers (`reg_sel`=0 source, 1 destination) into the working pointers. A control write made while the channel is enabled leaves the working pointers alone, even after the programmed source has been rewritten.
- R2: Each unit reads from the working source pointer. It then writes the returned read data to the working destination pointer.
- R3: Control bits 22:21 choose how the destination pointer moves: 0 steps up, 1 steps down, 2 stays fixed. Code 3 steps up and also reloads the working destination from the programmed destination at every burst start.
- R4: Control bits 24:23 choose how the source pointer moves: 0 steps up, 1 steps down, 2 stays fixed. Code 3 acts as step up.
- R5: When control bit 26 is 1, units are 32 bits, pointers move by 4 and `mem_wide` is 1. When bit 26 is 0, units are 16 bits, pointers move by 2 and `mem_wide` is 0.
- R6: The unit count is control bits CNT_W-1:0. A count of 0 moves 2^CNT_W units.
- R7: Control bits 29:27 hold the start mode. Mode 0 starts one cycle after arming. Mode m (1 to 7) starts a burst only on a pulse of `trig_req[m]` while the channel is enabled and idle. Pulses on the other request lines do nothing.
- R8: In mode 7 a burst moves at most 112 units. When units remain after a burst, the channel goes idle and keeps its count and pointers until the next request.
- R9: After each write handshake the channel waits idle for ws(src)+ws(dst) cycles before its next request. The regions are pointer bits 27:24. For 16-bit units, regions 8 and 9 cost 6, region A costs 10 and all others cost 1. For 32-bit units, regions 2, 5 and 6 cost 2, regions 8 and 9 cost 12, region A costs 10 and all others cost 1.
- R10: `cpu_stall` is 1 from the start of a burst until the wait that follows its last write is over. It is 0 when the channel is idle or paused.
- R11: When the count runs out, bit 31 clears unless bit 25 (repeat) is set and the mode is not 0. A repeating channel reloads its count at its next request. If bit 30 is set, `irq` pulses for exactly one cycle as the stall drops.
- R12: `ctl_rd` returns the control word as written, with the live enable bit, and with the count field not decremented.
- R13: While `mem_valid` is high and `mem_ready` is low, the address, direction and write data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 source, 1 destination, 2 control |
| reg_wdata | input | 32 | Register write data |
| ctl_rd | output | 32 | Control word readback |
| trig_req | input | 8 | Request line per start mode (bit 0 unused) |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_wide | output | 1 | 1 for a 32-bit unit, 0 for a 16-bit unit |
| mem_addr | output | 32 | Request address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the read handshake cycle |
| cpu_stall | output | 1 | Processor stall while a burst runs |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The in-line properties check on every cycle that a request stalled by the memory holds steady and that the interrupt never lasts two cycles. They also check that a burst starts only with the enable bit set, that no access is issued once the count is exhausted, and that a FIFO-mode burst never holds more than 112 units. The bench's scenarios are needed for the rest. These are the address sequences for every step code, the exact idle gap after each write for several regions and both unit sizes, and the pause and resume across FIFO bursts with a zero count. They also cover the no-relatch rule on a rewrite while enabled, and the enable and readback state after plain, repeating and interrupting transfers.

// File: rtl/mdma_pkg.sv
`timescale 1ns/1ps
package mdma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_WAIT} mdma_state_e;

  localparam int EN_BIT   = 31;
  localparam int IE_BIT   = 30;
  localparam int MODE_LO  = 27;
  localparam int WIDE_BIT = 26;
  localparam int RPT_BIT  = 25;
  localparam int SRC_LO   = 23;
  localparam int DST_LO   = 21;

  localparam logic [1:0] STEP_UP   = 2'd0;
  localparam logic [1:0] STEP_DOWN = 2'd1;
  localparam logic [1:0] STEP_HOLD = 2'd2;
  localparam logic [1:0] STEP_RELD = 2'd3;

  // wait-state cost of one access to a region
  function automatic logic [3:0] region_ws(input logic [3:0] rg, input logic wide);
    case (rg)
      4'h8, 4'h9:       return wide ? 4'd12 : 4'd6;
      4'hA:             return 4'd10;
      4'h2, 4'h5, 4'h6: return wide ? 4'd2 : 4'd1;
      default:          return 4'd1;
    endcase
  endfunction
endpackage

// File: rtl/mdma_step.sv
`timescale 1ns/1ps
module mdma_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur,
  input  logic [1:0]    code,
  input  logic          wide,
  output logic [AW-1:0] nxt
);
  import mdma_pkg::*;
  logic [AW-1:0] sz;
  assign sz = wide ? AW'(4) : AW'(2);

  always_comb begin
    case (code)
      STEP_DOWN: nxt = cur - sz;
      STEP_HOLD: nxt = cur;
      default:   nxt = cur + sz;   // up, and code 3 behaves as up
    endcase
  end
endmodule

// File: rtl/mdma_cost.sv
`timescale 1ns/1ps
module mdma_cost (
  input  logic [3:0] src_rg,
  input  logic [3:0] dst_rg,
  input  logic       wide,
  output logic [4:0] cost
);
  import mdma_pkg::*;
  assign cost = {1'b0, region_ws(src_rg, wide)} + {1'b0, region_ws(dst_rg, wide)};
endmodule

// File: rtl/mdma_channel.sv
`timescale 1ns/1ps
module mdma_channel #(
  parameter int CNT_W     = 21,
  parameter int BURST_MAX = 112,
  parameter int FIFO_MODE = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] ctl_rd,
  input  logic [7:0]  trig_req,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic        mem_we,
  output logic        mem_wide,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        cpu_stall,
  output logic        irq
);
  import mdma_pkg::*;
  localparam int REM_W = CNT_W + 1;

  mdma_state_e st;
  logic [31:0] src_q, dst_q, ctrl_q, cur_src, cur_dst, data_q;
  logic [REM_W-1:0] rem, iter, load_val, rem_start, burst_cap;
  logic [4:0] wcnt, cost;
  logic kick, in_prog, go, arm;

  logic [2:0] mode;
  logic       wide;
  logic [1:0] scode, dcode;
  assign mode  = ctrl_q[MODE_LO +: 3];
  assign wide  = ctrl_q[WIDE_BIT];
  assign scode = ctrl_q[SRC_LO +: 2];
  assign dcode = ctrl_q[DST_LO +: 2];

  // pointer steppers, one per side
  logic [31:0] cur_a [2];
  logic [31:0] nxt_a [2];
  logic [1:0]  code_a [2];
  assign cur_a[0] = cur_src;  assign code_a[0] = scode;
  assign cur_a[1] = cur_dst;  assign code_a[1] = dcode;
  for (genvar gi = 0; gi < 2; gi++) begin : g_step
    mdma_step #(.AW(32)) u_step (
      .cur (cur_a[gi]),
      .code(code_a[gi]),
      .wide(wide),
      .nxt (nxt_a[gi])
    );
  end

  mdma_cost u_cost (
    .src_rg(cur_src[27:24]),
    .dst_rg(cur_dst[27:24]),
    .wide  (wide),
    .cost  (cost)
  );

  assign load_val  = (ctrl_q[CNT_W-1:0] == '0) ? (REM_W'(1) << CNT_W)
                                               : {1'b0, ctrl_q[CNT_W-1:0]};
  assign rem_start = in_prog ? rem : load_val;
  assign burst_cap = (mode == 3'(FIFO_MODE) && rem_start > REM_W'(BURST_MAX))
                     ? REM_W'(BURST_MAX) : rem_start;
  assign arm = reg_we && reg_sel == 2'd2 && !ctrl_q[EN_BIT] && reg_wdata[EN_BIT];
  assign go  = st == ST_IDLE && ctrl_q[EN_BIT]
               && (kick || (mode != 3'd0 && trig_req[mode]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      src_q <= '0; dst_q <= '0; ctrl_q <= '0;
      cur_src <= '0; cur_dst <= '0; data_q <= '0;
      rem <= '0; iter <= '0; wcnt <= '0;
      kick <= 1'b0; in_prog <= 1'b0; irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (reg_we) begin
        case (reg_sel)
          2'd0:    src_q  <= reg_wdata;
          2'd1:    dst_q  <= reg_wdata;
          2'd2:    ctrl_q <= reg_wdata;
          default: ;
        endcase
      end
      if (arm) begin
        cur_src <= src_q;
        cur_dst <= dst_q;
        in_prog <= 1'b0;
        kick    <= (reg_wdata[MODE_LO +: 3] == 3'd0);
      end
      case (st)
        ST_IDLE: if (go) begin
          kick    <= 1'b0;
          in_prog <= 1'b1;
          rem     <= rem_start;
          iter    <= burst_cap;
          if (dcode == STEP_RELD) cur_dst <= dst_q;
          st <= ST_RD;
        end
        ST_RD: if (mem_ready) begin
          data_q <= mem_rdata;
          st     <= ST_WR;
        end
        ST_WR: if (mem_ready) begin
          cur_src <= nxt_a[0];
          cur_dst <= nxt_a[1];
          rem     <= rem - 1'b1;
          iter    <= iter - 1'b1;
          wcnt    <= cost - 5'd1;
          st      <= ST_WAIT;
        end
        ST_WAIT: begin
          if (wcnt != 5'd0) wcnt <= wcnt - 5'd1;
          else if (rem == '0) begin
            st      <= ST_IDLE;
            in_prog <= 1'b0;
            if (!(ctrl_q[RPT_BIT] && mode != 3'd0)) ctrl_q[EN_BIT] <= 1'b0;
            irq <= ctrl_q[IE_BIT];
          end else if (iter == '0 || !ctrl_q[EN_BIT]) st <= ST_IDLE;
          else st <= ST_RD;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mem_valid = (st == ST_RD) || (st == ST_WR);
  assign mem_we    = (st == ST_WR);
  assign mem_addr  = (st == ST_WR) ? cur_dst : cur_src;
  assign mem_wdata = data_q;
  assign mem_wide  = wide;
  assign cpu_stall = (st != ST_IDLE);
  assign ctl_rd    = ctrl_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata)); // R13
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R11
  AST_START_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_stall) |-> ctrl_q[EN_BIT]); // R7
  AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> rem != '0); // R6
  AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stall && mode == 3'(FIFO_MODE)) |-> iter <= REM_W'(BURST_MAX)); // R8
endmodule

// File: tb/sim_mdma_channel.sv
`timescale 1ns/1ps
module sim_mdma_channel;
  localparam int CW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic rst_n = 1'b0, reg_we = 1'b0, mem_ready = 1'b1;
  logic [1:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [7:0] trig_req = '0;
  logic [31:0] ctl_rd, mem_addr, mem_wdata, mem_rdata;
  logic mem_valid, mem_we, mem_wide, cpu_stall, irq;

  function automatic logic [31:0] rd_fn(input logic [31:0] a);
    return a ^ 32'h5A5A_C3C3;
  endfunction
  assign mem_rdata = rd_fn(mem_addr);

  mdma_channel #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctl_rd(ctl_rd), .trig_req(trig_req),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .cpu_stall(cpu_stall), .irq(irq)
  );

  int nchk = 0, nfail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int ws(input int rg, input bit w);
    if (rg == 8 || rg == 9) return w ? 12 : 6;
    if (rg == 10) return 10;
    if (rg == 2 || rg == 5 || rg == 6) return w ? 2 : 1;
    return 1;
  endfunction

  function automatic logic [31:0] stp(input logic [31:0] a, input logic [1:0] c, input bit w);
    int sz;
    sz = w ? 4 : 2;
    if (c == 2'd1) return a - sz;
    if (c == 2'd2) return a;
    return a + sz;
  endfunction

  function automatic logic [31:0] cw(input bit en, input bit ie, input int md, input bit w,
                                     input bit rpt, input int sc, input int dc, input int cnt);
    return {en, ie, 3'(md), w, rpt, 2'(sc), 2'(dc), 21'(cnt)};
  endfunction

  // behavioural reference model
  logic [31:0] m_src = '0, m_dst = '0, p_src = '0, p_dst = '0, m_ctrl = '0;
  int m_left = 0, m_total = 0, since = 0, cost = 0, units = 0;
  bit m_inprog = 0, m_wr = 0, m_track = 0, run_model = 0;

  task automatic model_start();
    if (!m_inprog) begin
      m_total  = (m_ctrl[CW-1:0] == 0) ? (1 << CW) : int'(m_ctrl[CW-1:0]);
      m_inprog = 1;
    end
    m_left = (m_ctrl[29:27] == 3'd7 && m_total > 112) ? 112 : m_total;
    if (m_ctrl[22:21] == 2'd3) m_dst = p_dst;
  endtask

  always @(negedge clk) begin
    if (rst_n && run_model) begin
      if (m_track) begin
        since++;
        if (since <= cost) begin
          chk(!mem_valid && cpu_stall, "R9", "idle gap after write", {mem_valid, cpu_stall}, 32'h1);
        end else begin
          m_track = 0;
          if (m_left > 0)
            chk(mem_valid && !mem_we, "R9", "read after wait gap", mem_valid, 1);
          else begin
            chk(!cpu_stall, "R10", "stall released at burst end", cpu_stall, 0);
            chk(irq == (m_total == 0 && m_ctrl[30]), "R11", "completion irq", irq,
                32'(m_total == 0 && m_ctrl[30]));
          end
        end
      end else begin
        chk(!irq, "R11", "no stray irq", irq, 0);
        if (m_left == 0) chk(!mem_valid, "R7", "no access while not started", mem_valid, 0);
      end
      if (mem_valid && mem_ready) begin
        if (m_left == 0) chk(0, "R7", "unexpected access", mem_addr, 0);
        else if (!m_wr) begin
          chk(!mem_we && mem_addr == m_src, "R1 R4", "read address", mem_addr, m_src);
          m_wr = 1;
        end else begin
          chk(mem_we && mem_addr == m_dst, "R3", "write address", mem_addr, m_dst);
          chk(mem_wdata == rd_fn(m_src), "R2", "write data", mem_wdata, rd_fn(m_src));
          chk(mem_wide == m_ctrl[26], "R5", "unit size", mem_wide, m_ctrl[26]);
          cost = ws(int'(m_src[27:24]), m_ctrl[26]) + ws(int'(m_dst[27:24]), m_ctrl[26]);
          m_src = stp(m_src, m_ctrl[24:23], m_ctrl[26]);
          m_dst = stp(m_dst, m_ctrl[22:21], m_ctrl[26]);
          m_left--; m_total--; units++;
          m_wr = 0; m_track = 1; since = 0;
          if (m_total == 0) begin
            m_inprog = 0;
            if (!(m_ctrl[25] && m_ctrl[29:27] != 0)) m_ctrl[31] = 1'b0;
          end
        end
      end
    end
  end

  bit slow = 0;
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    #1 mem_ready = slow ? (cyc % 3 != 0) : 1'b1;
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    if (sel == 0) p_src = d;
    if (sel == 1) p_dst = d;
    if (sel == 2) begin
      bit armed;
      armed  = !m_ctrl[31] && d[31];
      m_ctrl = d;
      if (armed) begin
        m_src = p_src; m_dst = p_dst; m_inprog = 0;
        if (d[29:27] == 0) model_start();
      end
    end
    @(posedge clk); #1 reg_we = 0;
  endtask

  task automatic trig(input int m);
    @(posedge clk); #1;
    trig_req[m] = 1'b1;
    if (m_ctrl[31] && m != 0 && int'(m_ctrl[29:27]) == m) model_start();
    @(posedge clk); #1 trig_req = '0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (m_left == 0 && !m_track) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_valid && !cpu_stall && !irq, "R10", "reset outputs idle",
        {mem_valid, cpu_stall, irq}, 0);
    chk(ctl_rd == 0, "R12", "reset readback", ctl_rd, 0);
    run_model = 1;

    // T1: immediate, 32-bit, both up, count 3, irq
    wr(0, 32'h0200_0000); wr(1, 32'h0300_0100);
    units = 0;
    wr(2, cw(1, 1, 0, 1, 0, 0, 0, 3));
    wait_done();
    chk(units == 3, "R6", "unit count", units, 3);
    chk(ctl_rd == m_ctrl, "R11 R12", "readback after finish", ctl_rd, m_ctrl);

    // T2: 16-bit, src down, dst fixed, slow memory, repeat with mode 0
    slow = 1;
    wr(0, 32'h0800_0010); wr(1, 32'h0400_0000);
    units = 0;
    wr(2, cw(1, 0, 0, 0, 1, 1, 2, 4));
    wait_done();
    chk(units == 4, "R5", "16-bit units moved", units, 4);
    chk(ctl_rd == m_ctrl && !ctl_rd[31], "R11", "enable cleared in mode 0", ctl_rd, m_ctrl);
    slow = 0;

    // T3: triggered mode 1, repeat, src code 3, dst reload code 3
    wr(0, 32'h0300_0000); wr(1, 32'h0400_0020);
    wr(2, cw(1, 1, 1, 1, 1, 3, 3, 2));
    repeat (20) @(negedge clk);
    chk(!cpu_stall, "R7", "waits for request", cpu_stall, 0);
    trig(2);
    repeat (10) @(negedge clk);
    chk(!cpu_stall, "R7", "other request line ignored", cpu_stall, 0);
    trig(1);
    wait_done();
    chk(ctl_rd == m_ctrl && ctl_rd[31], "R11", "repeat keeps enable", ctl_rd, m_ctrl);
    chk(ctl_rd[CW-1:0] == 2, "R12", "count reads as written", ctl_rd[CW-1:0], 2);
    wr(0, 32'h0500_0000);
    wr(2, cw(1, 1, 1, 1, 1, 3, 3, 2));     // rewrite while enabled: no relatch (R1)
    trig(1);
    wait_done();
    wr(2, 32'h0);
    wr(2, cw(1, 0, 1, 1, 0, 3, 3, 2));     // fresh 0->1: relatch (R1)
    trig(1);
    wait_done();
    chk(ctl_rd == m_ctrl && !ctl_rd[31], "R11", "enable cleared without repeat", ctl_rd, m_ctrl);

    // T4: FIFO mode, zero count, 16-bit, bursts of 112
    wr(0, 32'h0200_0000); wr(1, 32'h0400_0400);
    units = 0;
    wr(2, cw(1, 1, 7, 0, 0, 0, 2, 0));
    trig(7); wait_done();
    chk(units == 112, "R8", "first burst size", units, 112);
    chk(!cpu_stall && ctl_rd[31], "R8", "paused and still enabled", {cpu_stall, ctl_rd[31]}, 1);
    trig(7); wait_done();
    chk(units == 224, "R8", "second burst size", units, 224);
    trig(7); wait_done();
    chk(units == 256, "R6", "zero count moves 2^CNT_W", units, 256);
    chk(ctl_rd == m_ctrl, "R12", "readback after FIFO run", ctl_rd, m_ctrl);

    finish_run();
  end
endmodule